// File: doc/BRIEF.md
# Register Rename Map with Ready Tracking

This block gives each architectural register write a new internal name, which removes write-after-write and write-after-read conflicts between in-flight instructions. It keeps three structures. A map table points each of the eight architectural registers at one of 32 internal tags. A free bitmap records which tags can be handed out. A ready bit per tag records whether that tag's result has been produced.

Each cycle, one instruction may present up to two source register numbers and an optional destination register number. The block returns the current tag and ready state for each source in the same cycle. For a destination, it takes the lowest-numbered free tag, clears that tag's ready bit and points the map entry at it. The map update is visible from the next cycle on.

A result broadcast input marks a tag ready. A release input lets the surrounding logic hand back a tag that nothing pending refers to any more. The block frees that tag only if no map entry still points at it. When a destination is needed and no tag is free, the block raises a stall and leaves all of its state unchanged.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register k maps to tag k and tag k is ready, for k = 0..7. Tags 8..31 are free and the first destination receives tag 8.
- R2: An accepted instruction with a destination (issue_valid_i=1, dst_valid_i=1, stall_o=0) updates the map entry for dst_i so that it points to the tag shown on dst_tag_o in that cycle.
- R3: Source lookups read the map as it stood before the current instruction is renamed. A register written by the previous accepted instruction yields that instruction's tag. A source equal to the current instruction's destination yields the old tag.
- R4: A newly allocated tag reads not-ready from the cycle after its allocation. A broadcast of a tag makes it read ready from the next cycle on.
- R5: When a broadcast carries the same tag that a source lookup returns in that cycle, that source reports ready in the same cycle.
- R6: The allocated tag is always the lowest-numbered free tag.
- R7: When issue_valid_i=1, dst_valid_i=1 and no tag is free, stall_o is 1. In that case no tag is allocated and no map entry changes.
- R8: An instruction with dst_valid_i=0 allocates nothing, and stall_o stays 0 even when the pool is empty.
- R9: A release frees its tag from the next cycle only if no map entry points to that tag in the release cycle. A release of a mapped tag has no effect.
- R10: With issue_valid_i=0, the map table and the free pool do not change, whatever the other issue inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | An instruction is presented this cycle |
| src_a_i | input | 3 | First source architectural register |
| src_b_i | input | 3 | Second source architectural register |
| dst_valid_i | input | 1 | Instruction writes a destination register |
| dst_i | input | 3 | Destination architectural register |
| src_a_tag_o | output | 5 | Tag currently mapped to src_a_i |
| src_a_rdy_o | output | 1 | Ready state of src_a_tag_o, including broadcast bypass |
| src_b_tag_o | output | 5 | Tag currently mapped to src_b_i |
| src_b_rdy_o | output | 1 | Ready state of src_b_tag_o, including broadcast bypass |
| dst_tag_o | output | 5 | Tag allocated to the destination when accepted |
| stall_o | output | 1 | Destination needed but the pool is empty |
| bcast_valid_i | input | 1 | Result broadcast valid |
| bcast_tag_i | input | 5 | Tag of the broadcast result |
| release_valid_i | input | 1 | Tag release request |
| release_tag_i | input | 5 | Tag to return to the pool |

## Verification
The lookup outputs, dst_tag_o and stall_o are combinational functions of the stored state and the current inputs. They are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs 2 ns later, well before the next rising edge.

Map writes, allocation, ready-bit changes and releases take effect at the rising edge. They become visible one cycle after the stimulus. The bench updates its own model only after that edge, and compares the next cycle's outputs against the updated model.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned ARCH_REGS_DEF = 8;
  localparam int unsigned NUM_TAGS_DEF  = 32;
endpackage

// File: rtl/rename_map_tbl.sv
module rename_map_tbl #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned NUM_TAGS  = 32,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned TW = $clog2(NUM_TAGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       rd_a_i,
  input  logic [AW-1:0]       rd_b_i,
  output logic [TW-1:0]       tag_a_o,
  output logic [TW-1:0]       tag_b_o,
  input  logic                we_i,
  input  logic [AW-1:0]       wr_idx_i,
  input  logic [TW-1:0]       wr_tag_i,
  output logic [NUM_TAGS-1:0] mapped_o
);
  logic [ARCH_REGS-1:0][TW-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ARCH_REGS; k++) map_q[k] <= TW'(k);
    end else if (we_i) begin
      map_q[wr_idx_i] <= wr_tag_i;
    end
  end

  assign tag_a_o = map_q[rd_a_i];
  assign tag_b_o = map_q[rd_b_i];

  always_comb begin
    mapped_o = '0;
    for (int k = 0; k < ARCH_REGS; k++) mapped_o[map_q[k]] = 1'b1;
  end

  assert_map_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> map_q[$past(wr_idx_i)] == $past(wr_tag_i));
  assert_map_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(map_q));
endmodule

// File: rtl/rename_free_pool.sv
module rename_free_pool #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned NUM_TAGS  = 32,
  localparam int unsigned TW = $clog2(NUM_TAGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  output logic [TW-1:0]       alloc_tag_o,
  output logic                empty_o,
  input  logic                rel_valid_i,
  input  logic [TW-1:0]       rel_tag_i,
  input  logic [NUM_TAGS-1:0] mapped_i
);
  logic [NUM_TAGS-1:0] free_q, free_d;
  logic                rel_ok;

  assign rel_ok = rel_valid_i && !mapped_i[rel_tag_i];

  // lowest set bit wins
  always_comb begin
    alloc_tag_o = '0;
    for (int t = NUM_TAGS - 1; t >= 0; t--) begin
      if (free_q[t]) alloc_tag_o = TW'(t);
    end
  end

  assign empty_o = ~|free_q;

  always_comb begin
    free_d = free_q;
    if (rel_ok)  free_d[rel_tag_i]   = 1'b1;
    if (alloc_i) free_d[alloc_tag_o] = 1'b0;
  end

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_free
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) free_q[g] <= (g >= ARCH_REGS);
      else         free_q[g] <= free_d[g];
    end
  end

  assert_alloc_from_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !empty_o && free_q[alloc_tag_o]);
  assert_alloc_lowest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (free_q & ((NUM_TAGS'(1) << alloc_tag_o) - NUM_TAGS'(1))) == '0);
  assert_alloc_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> !free_q[$past(alloc_tag_o)]);
  assert_release_mapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i && mapped_i[rel_tag_i] && !(alloc_i && alloc_tag_o == rel_tag_i)
    |=> free_q[$past(rel_tag_i)] == $past(free_q[rel_tag_i]));
endmodule

// File: rtl/rename_ready_tbl.sv
module rename_ready_tbl #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned NUM_TAGS  = 32,
  localparam int unsigned TW = $clog2(NUM_TAGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bc_valid_i,
  input  logic [TW-1:0] bc_tag_i,
  input  logic          clr_i,
  input  logic [TW-1:0] clr_tag_i,
  input  logic [TW-1:0] q_a_i,
  input  logic [TW-1:0] q_b_i,
  output logic          rdy_a_o,
  output logic          rdy_b_o
);
  logic [NUM_TAGS-1:0] rdy_q;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_rdy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  rdy_q[g] <= (g < ARCH_REGS);
      else if (clr_i && clr_tag_i == TW'(g))        rdy_q[g] <= 1'b0;
      else if (bc_valid_i && bc_tag_i == TW'(g))    rdy_q[g] <= 1'b1;
    end
  end

  // same-cycle broadcast bypass
  assign rdy_a_o = rdy_q[q_a_i] || (bc_valid_i && bc_tag_i == q_a_i);
  assign rdy_b_o = rdy_q[q_b_i] || (bc_valid_i && bc_tag_i == q_b_i);

  assert_clear_on_alloc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !rdy_q[$past(clr_tag_i)]);
  assert_set_on_bcast_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_valid_i && !(clr_i && clr_tag_i == bc_tag_i) |=> rdy_q[$past(bc_tag_i)]);
endmodule

// File: rtl/rename_map.sv
module rename_map #(
  parameter int unsigned ARCH_REGS = rename_pkg::ARCH_REGS_DEF,
  parameter int unsigned NUM_TAGS  = rename_pkg::NUM_TAGS_DEF,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned TW = $clog2(NUM_TAGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_valid_i,
  input  logic [AW-1:0] src_a_i,
  input  logic [AW-1:0] src_b_i,
  input  logic          dst_valid_i,
  input  logic [AW-1:0] dst_i,
  output logic [TW-1:0] src_a_tag_o,
  output logic          src_a_rdy_o,
  output logic [TW-1:0] src_b_tag_o,
  output logic          src_b_rdy_o,
  output logic [TW-1:0] dst_tag_o,
  output logic          stall_o,
  input  logic          bcast_valid_i,
  input  logic [TW-1:0] bcast_tag_i,
  input  logic          release_valid_i,
  input  logic [TW-1:0] release_tag_i
);
  logic                need_tag, alloc, empty;
  logic [TW-1:0]       new_tag;
  logic [NUM_TAGS-1:0] mapped;

  assign need_tag  = issue_valid_i && dst_valid_i;
  assign stall_o   = need_tag && empty;
  assign alloc     = need_tag && !empty;
  assign dst_tag_o = new_tag;

  rename_map_tbl #(.ARCH_REGS(ARCH_REGS), .NUM_TAGS(NUM_TAGS)) i_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_a_i   (src_a_i),
    .rd_b_i   (src_b_i),
    .tag_a_o  (src_a_tag_o),
    .tag_b_o  (src_b_tag_o),
    .we_i     (alloc),
    .wr_idx_i (dst_i),
    .wr_tag_i (new_tag),
    .mapped_o (mapped)
  );

  rename_free_pool #(.ARCH_REGS(ARCH_REGS), .NUM_TAGS(NUM_TAGS)) i_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .alloc_tag_o (new_tag),
    .empty_o     (empty),
    .rel_valid_i (release_valid_i),
    .rel_tag_i   (release_tag_i),
    .mapped_i    (mapped)
  );

  rename_ready_tbl #(.ARCH_REGS(ARCH_REGS), .NUM_TAGS(NUM_TAGS)) i_rdy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bc_valid_i (bcast_valid_i),
    .bc_tag_i   (bcast_tag_i),
    .clr_i      (alloc),
    .clr_tag_i  (new_tag),
    .q_a_i      (src_a_tag_o),
    .q_b_i      (src_b_tag_o),
    .rdy_a_o    (src_a_rdy_o),
    .rdy_b_o    (src_b_rdy_o)
  );

  assert_bypass_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_valid_i && bcast_tag_i == src_a_tag_o |-> src_a_rdy_o);
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_i |=> $stable(src_a_tag_o) || $past(src_a_i) != src_a_i);
endmodule

// File: tb/test_rename_map.sv
`timescale 1ns/1ps
module test_rename_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iv = 0, dv = 0, bv = 0, rv = 0;
  logic [2:0] sa = 0, sb = 0, ds = 0;
  logic [4:0] bt = 0, rt = 0;
  logic [4:0] a_tag, b_tag, d_tag;
  logic       a_rdy, b_rdy, stall;

  int n_chk = 0, n_bad = 0;
  int mmap[8];
  bit mfree[32];
  bit mrdy[32];

  always #10 clk = ~clk;

  rename_map i_rename_map (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(iv), .src_a_i(sa), .src_b_i(sb),
    .dst_valid_i(dv), .dst_i(ds), .src_a_tag_o(a_tag), .src_a_rdy_o(a_rdy),
    .src_b_tag_o(b_tag), .src_b_rdy_o(b_rdy), .dst_tag_o(d_tag), .stall_o(stall),
    .bcast_valid_i(bv), .bcast_tag_i(bt), .release_valid_i(rv), .release_tag_i(rt)
  );

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int t = 0; t < 32; t++) if (mfree[t]) return t;
    return -1;
  endfunction

  function automatic bit is_mapped(int t);
    for (int k = 0; k < 8; k++) if (mmap[k] == t) return 1'b1;
    return 1'b0;
  endfunction

  // one cycle: drive at falling edge, check combinational outputs, advance model after rising edge
  task automatic step(bit i_v, int a, int b, bit d_v, int d, bit b_v, int b_t, bit r_v, int r_t);
    int ea, eb, lf;
    bit bya, byb;
    @(negedge clk);
    iv = i_v; sa = 3'(a); sb = 3'(b); dv = d_v; ds = 3'(d);
    bv = b_v; bt = 5'(b_t); rv = r_v; rt = 5'(r_t);
    #2;
    ea = mmap[a]; eb = mmap[b];
    bya = b_v && (b_t == ea); byb = b_v && (b_t == eb);
    check("R2 R3 src_a tag", a_tag, ea);
    check("R2 R3 src_b tag", b_tag, eb);
    check(bya ? "R5 src_a rdy" : "R4 src_a rdy", a_rdy, mrdy[ea] | bya);
    check(byb ? "R5 src_b rdy" : "R4 src_b rdy", b_rdy, mrdy[eb] | byb);
    lf = lowest_free();
    check(d_v ? "R7 stall" : "R8 stall", stall, (i_v && d_v && lf < 0) ? 1 : 0);
    if (i_v && d_v && lf >= 0) check("R6 dst tag", d_tag, lf);
    @(posedge clk);
    if (b_v) mrdy[b_t] = 1'b1;
    if (r_v && !is_mapped(r_t)) mfree[r_t] = 1'b1;
    if (i_v && d_v && lf >= 0) begin
      mfree[lf] = 1'b0; mrdy[lf] = 1'b0; mmap[d] = lf;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int victim, pre, last;
    for (int k = 0; k < 8; k++) begin mmap[k] = k; end
    for (int t = 0; t < 32; t++) begin mfree[t] = (t >= 8); mrdy[t] = (t < 8); end
    #35 rst_n = 1'b1;

    // R1: reset state, every register looked up
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); sa = 3'(k); sb = 3'(7 - k); #2;
      check("R1 reset tag", a_tag, k);
      check("R1 reset rdy", a_rdy, 1);
      check("R1 reset stall", stall, 0);
    end
    @(negedge clk); iv = 1; dv = 1; ds = 3'd1; #2;
    check("R1 first alloc", d_tag, 8);
    iv = 0; dv = 0;

    // r1 <- r2 op r3 ; r7 <- r1 op r3 ; r1 <- r1 op r7
    step(1, 2, 3, 1, 1, 0, 0, 0, 0);
    step(1, 1, 3, 1, 7, 0, 0, 0, 0);
    step(1, 1, 7, 1, 1, 0, 0, 0, 0);
    idle();
    // R5 bypass on tag 9 (r7), then R4 held ready
    step(0, 7, 1, 0, 0, 1, 9, 0, 0);
    step(0, 7, 1, 0, 0, 0, 0, 0, 0);
    // R4 broadcast of r1's tag visible next cycle
    step(0, 1, 1, 0, 0, 1, 10, 0, 0);
    step(0, 1, 7, 0, 0, 0, 0, 0, 0);
    // R8 no destination, nothing allocated
    pre = lowest_free();
    step(1, 4, 5, 0, 3, 0, 0, 0, 0);
    check("R8 pool untouched", lowest_free(), pre);
    step(1, 3, 3, 1, 3, 0, 0, 0, 0);

    // R10 idle issue with destination fields set
    step(0, 3, 3, 1, 3, 0, 0, 0, 0);
    @(negedge clk); iv = 0; dv = 0; sa = 3'd3; #2;
    check("R10 map held", a_tag, mmap[3]);
    check("R10 pool held", d_tag, lowest_free());

    // R6 fill the pool with a sweep over destinations, broadcasting as results return
    last = 0;
    for (int i = 0; lowest_free() >= 0 && i < 64; i++) begin
      step(1, (i + 2) % 8, (i + 5) % 8, 1, i % 8, i > 0, last, 0, 0);
      last = mmap[i % 8];
    end
    // R7 empty pool stalls and keeps the map
    pre = mmap[4];
    step(1, 4, 0, 1, 4, 0, 0, 0, 0);
    step(1, 4, 4, 0, 0, 0, 0, 0, 0);
    check("R7 map after stall", a_tag, pre);

    // R9 release of a mapped tag is ignored
    step(0, 0, 0, 0, 0, 0, 0, 1, mmap[2]);
    @(negedge clk); iv = 1; dv = 1; ds = 3'd5; rv = 0; #2;
    check("R9 mapped release ignored", stall, 1);
    iv = 0; dv = 0;

    // R9 release of unmapped tags; lowest comes back first
    victim = -1;
    for (int t = 31; t >= 0; t--) if (!mfree[t] && !is_mapped(t)) victim = t;
    step(0, 0, 0, 0, 0, 0, 0, 1, victim + 1 + (is_mapped(victim + 1) ? 0 : 0));
    step(0, 0, 0, 0, 0, 0, 0, 1, victim);
    @(negedge clk); iv = 1; dv = 1; ds = 3'd5; #2;
    check("R9 freed tag stall", stall, 0);
    check("R9 lowest released tag", d_tag, victim);
    iv = 0; dv = 0;
    step(1, 5, 6, 1, 5, 0, 0, 0, 0);
    step(1, 5, 6, 1, 6, 0, 0, 0, 0);
    step(1, 5, 6, 0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule